// File: doc/BRIEF.md
# Attention Request Sequencer

This block raises an attention request to a disk attachment through a byte-wide register bus. A single start pulse carries three things: the attention kind (command request, end of interrupt or reset), the target device number, and the interrupt identifier that the request acknowledges. The block then runs a fixed handshake of register accesses and reports one `done_o` pulse. When the attachment stays busy for too long, that pulse comes with `tmo_o`.

The handshake has four steps. The block first masks interrupts in the control register. It then polls the busy flag in the status register, and the poll has an upper bound. Next it writes the attention register. Finally it unmasks interrupts again.

The poll is skipped when the request acknowledges a reset-completed interrupt, because the attachment may still show busy at that point. Device numbers 0 and 1 address disks and device number 7 addresses the controller. The attachment itself is not part of this block.

Top module: `attn_sequencer`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `tmo_o` and `bus_en_o` are all low, and no register access occurs until a start is accepted.
- R2: When `start_i` is accepted in idle, the very next bus cycle writes 0x00 to the control register (address 0).
- R3: The poll reads the status register (address 1), one read per cycle, until a read returns bit 0 (busy) clear. All other status bits are ignored. The attention write happens in the cycle after the read that saw busy clear.
- R4: When `irq_id_i` equals the reset-completed code (4'hA by default), no status read occurs. The attention write directly follows the control-mask write, whatever the busy flag shows.
- R5: If 10000 consecutive status reads all show busy, the sequence ends with `done_o` and `tmo_o` high together for one cycle. In that case neither the attention register nor the unmasking write is accessed.
- R6: The attention write goes to address 2. Its byte carries the device number in bits 7:5, a zero in bit 4 and the attention kind in bits 3:0. Device 7 (controller) is valid.
- R7: After the attention write, the next cycle writes 0x01 (interrupt enable only) to the control register. In the cycle after that, `done_o` pulses with `tmo_o` low.
- R8: `busy_o` is high from the cycle after the accepted start up to the last register access. It is low in the cycle that shows `done_o`. A start raised while busy is ignored: it neither changes the byte written nor adds a sequence.
- R9: The poll count restarts on every accepted start. A sequence that follows a timeout again allows a full 10000 reads, and 9999 busy reads followed by a clear read succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| kind_i | input | 4 | Attention kind placed in bits 3:0 of the attention byte |
| dev_i | input | 3 | Device number placed in bits 7:5 |
| irq_id_i | input | 4 | Interrupt identifier being acknowledged |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tmo_o | output | 1 | With `done_o`: poll gave up |
| bus_en_o | output | 1 | Register access this cycle |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 2 | 0 control, 1 status, 2 attention |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, sampled at the edge ending a read cycle |

## Verification
The bench aims at the poll boundary in both directions. It drives 9999 busy reads before a clear read, which an off-by-one counter would turn into a spurious timeout. It also holds busy far past the limit, where a design that counts one read too many or too few would show a read count other than 10000, and a design that failed to abort would write the attention register. Both the reset-completed bypass and its absence are exercised while busy is held: a design that ignored the bypass would time out, and one that always bypassed would skip the reads. A start pulsed mid-sequence with a different device shows whether the latched fields or the sequence itself are disturbed. A timeout followed by a fresh run shows whether the counter carries stale state.

// File: rtl/attn_seq_pkg.sv
package attn_seq_pkg;
  localparam int KIND_W = 4;
  localparam int DEV_W  = 3;
  localparam int IRQ_W  = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MASK,
    S_POLL,
    S_ATTN,
    S_UNMASK
  } seq_st_t;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_ATTN = 2'd2;

  // Attention byte: device in the top three bits, kind in the low nibble.
  function automatic logic [7:0] pack_attn(input logic [KIND_W-1:0] kind,
                                           input logic [DEV_W-1:0] dev);
    return {dev, 1'b0, kind};
  endfunction

  // Control byte with only the interrupt-enable bit optionally set.
  function automatic logic [7:0] ctrl_word(input logic ien, input int ien_bit);
    logic [7:0] w;
    w = '0;
    w[ien_bit[2:0]] = ien;
    return w;
  endfunction
endpackage

// File: rtl/attn_poll_ctr.sv
module attn_poll_ctr #(
  parameter int MAX_TRIES = 10000,
  localparam int CW = $clog2(MAX_TRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic          last_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(MAX_TRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == LAST);

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= LAST);
  p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/attn_seq_fsm.sv
module attn_seq_fsm
  import attn_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    skip_i,
  input  logic    busy_seen_i,
  input  logic    last_i,
  output seq_st_t st_o,
  output logic    accept_o,
  output logic    clr_o,
  output logic    inc_o,
  output logic    fin_o,
  output logic    tmo_fin_o
);
  seq_st_t st_d;

  always_comb begin
    st_d      = st_o;
    accept_o  = 1'b0;
    clr_o     = 1'b0;
    inc_o     = 1'b0;
    fin_o     = 1'b0;
    tmo_fin_o = 1'b0;
    unique case (st_o)
      S_IDLE: if (start_i) begin
        st_d     = S_MASK;
        accept_o = 1'b1;
        clr_o    = 1'b1;
      end
      S_MASK: st_d = skip_i ? S_ATTN : S_POLL;
      S_POLL: begin
        if (!busy_seen_i) st_d = S_ATTN;
        else if (last_i) begin
          st_d      = S_IDLE;
          tmo_fin_o = 1'b1;
        end else inc_o = 1'b1;
      end
      S_ATTN: st_d = S_UNMASK;
      S_UNMASK: begin
        st_d  = S_IDLE;
        fin_o = 1'b1;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_o <= S_IDLE;
    else        st_o <= st_d;
  end

  p_skip_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o == S_MASK && skip_i) |=> st_o == S_ATTN);
  p_poll_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o == S_POLL && !busy_seen_i) |=> st_o == S_ATTN);
  p_tmo_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fin_o |=> st_o == S_IDLE);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_o != S_IDLE && start_i) |-> !accept_o);
endmodule

// File: rtl/attn_bus_drv.sv
module attn_bus_drv
  import attn_seq_pkg::*;
#(
  parameter int IEN_BIT = 0
) (
  input  seq_st_t    st_i,
  input  logic [7:0] attn_byte_i,
  output logic       en_o,
  output logic       we_o,
  output logic [1:0] addr_o,
  output logic [7:0] wdata_o
);
  always_comb begin
    en_o    = 1'b1;
    we_o    = 1'b1;
    addr_o  = REG_CTRL;
    wdata_o = '0;
    unique case (st_i)
      S_MASK:   wdata_o = ctrl_word(1'b0, IEN_BIT);
      S_POLL: begin
        we_o   = 1'b0;
        addr_o = REG_STAT;
      end
      S_ATTN: begin
        addr_o  = REG_ATTN;
        wdata_o = attn_byte_i;
      end
      S_UNMASK: wdata_o = ctrl_word(1'b1, IEN_BIT);
      default: begin
        en_o = 1'b0;
        we_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/attn_sequencer.sv
module attn_sequencer
  import attn_seq_pkg::*;
#(
  parameter int              MAX_TRIES   = 10000,
  parameter int              BUSY_BIT    = 0,
  parameter int              IEN_BIT     = 0,
  parameter logic [IRQ_W-1:0] RST_DONE_ID = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [IRQ_W-1:0]  irq_id_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              tmo_o,
  output logic              bus_en_o,
  output logic              bus_we_o,
  output logic [1:0]        bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i
);
  localparam int CW = $clog2(MAX_TRIES + 1);

  seq_st_t           st;
  logic              accept, clr, inc, fin, tmo_fin, last, busy_seen, skip;
  logic [CW-1:0]     cnt;
  logic [KIND_W-1:0] kind_q;
  logic [DEV_W-1:0]  dev_q;
  logic [IRQ_W-1:0]  irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= '0;
      dev_q  <= '0;
      irq_q  <= '0;
    end else if (accept) begin
      kind_q <= kind_i;
      dev_q  <= dev_i;
      irq_q  <= irq_id_i;
    end
  end

  assign skip      = (irq_q == RST_DONE_ID);
  assign busy_seen = bus_rdata_i[BUSY_BIT];

  attn_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .skip_i(skip),
    .busy_seen_i(busy_seen), .last_i(last), .st_o(st), .accept_o(accept),
    .clr_o(clr), .inc_o(inc), .fin_o(fin), .tmo_fin_o(tmo_fin)
  );

  attn_poll_ctr #(.MAX_TRIES(MAX_TRIES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(inc),
    .last_o(last), .cnt_o(cnt)
  );

  attn_bus_drv #(.IEN_BIT(IEN_BIT)) u_bus (
    .st_i(st), .attn_byte_i(pack_attn(kind_q, dev_q)),
    .en_o(bus_en_o), .we_o(bus_we_o), .addr_o(bus_addr_o),
    .wdata_o(bus_wdata_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      tmo_o  <= 1'b0;
    end else begin
      done_o <= fin | tmo_fin;
      tmo_o  <= tmo_fin;
    end
  end

  assign busy_o = (st != S_IDLE);

  p_idle_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_en_o);
  p_mask_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (bus_en_o && bus_we_o && bus_addr_o == REG_CTRL
                       && bus_wdata_o == 8'h00));
  p_attn_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_o && bus_we_o && bus_addr_o == REG_ATTN)
      |-> (bus_wdata_o[4] == 1'b0 && bus_wdata_o[7:5] == dev_q));
  p_unmask_after_attn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en_o && bus_we_o && bus_addr_o == REG_ATTN)
      |=> (bus_en_o && bus_we_o && bus_addr_o == REG_CTRL
           && bus_wdata_o == ctrl_word(1'b1, IEN_BIT)));
  p_tmo_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> done_o);
  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(dev_q) && $stable(kind_q)));
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MASK) |-> cnt == '0);
endmodule

// File: tb/tb_attn_sequencer.sv
module tb_attn_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] kind_i = '0;
  logic [2:0] dev_i = '0;
  logic [3:0] irq_id_i = '0;
  logic       busy_o, done_o, tmo_o, bus_en_o, bus_we_o;
  logic [1:0] bus_addr_o;
  logic [7:0] bus_wdata_o;
  logic [7:0] bus_rdata_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  attn_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
    .dev_i(dev_i), .irq_id_i(irq_id_i), .busy_o(busy_o), .done_o(done_o),
    .tmo_o(tmo_o), .bus_en_o(bus_en_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i)
  );

  // Attachment model: status reads return busy until busy_target reads seen.
  int rd_total = 0, wr_total = 0, rd_base = 0, wr_base = 0, busy_target = 0;
  int first_rd_wr = -1, last_rd_wr = -1;
  logic [1:0] wr_addr [16];
  logic [7:0] wr_data [16];

  assign bus_rdata_i = {4'hA, 3'b000, ((rd_total - rd_base) < busy_target)};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (bus_en_o && !bus_we_o && bus_addr_o == 2'd1) begin
      if (rd_total == rd_base) first_rd_wr <= wr_total - wr_base;
      last_rd_wr <= wr_total - wr_base;
      rd_total <= rd_total + 1;
    end
    if (bus_en_o && bus_we_o) begin
      wr_addr[wr_total % 16] <= bus_addr_o;
      wr_data[wr_total % 16] <= bus_wdata_o;
      wr_total <= wr_total + 1;
    end
  end

  always @(negedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One sequence; poke_k > 0 raises a foreign start in that cycle.
  task automatic run(input logic [3:0] kind, input logic [2:0] dev,
                     input logic [3:0] irq, input int busy_n, input int poke_k);
    bit skip, tmo, busy_ok;
    int exp_rd, exp_wr, k, nrd, nwr;
    logic [7:0] exp_byte;
    skip = (irq == 4'hA);
    tmo = !skip && busy_n >= 10000;
    exp_rd = skip ? 0 : (tmo ? 10000 : busy_n + 1);
    exp_wr = tmo ? 1 : 3;
    exp_byte = {dev, 1'b0, kind};
    @(negedge clk);
    rd_base = rd_total; wr_base = wr_total; busy_target = busy_n;
    first_rd_wr = -1; last_rd_wr = -1;
    kind_i = kind; dev_i = dev; irq_id_i = irq; start_i = 1'b1;
    k = 0; busy_ok = 1;
    @(negedge clk); start_i = 1'b0;
    forever begin
      k++;
      if (done_o) break;
      if (!busy_o) busy_ok = 0;
      if (k == poke_k) begin
        start_i = 1'b1; dev_i = ~dev; kind_i = ~kind; irq_id_i = 4'hA;
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    nrd = rd_total - rd_base; nwr = wr_total - wr_base;
    chk(busy_ok && !busy_o, "R8 busy window", busy_o, 0);
    chk(k == exp_rd + exp_wr + 1, "R7 done latency", k, exp_rd + exp_wr + 1);
    chk(tmo_o == tmo, tmo ? "R5 timeout flag" : "R7 tmo low", tmo_o, tmo);
    chk(nrd == exp_rd, skip ? "R4 no reads" : (tmo ? "R5 read count" : "R3 read count"),
        nrd, exp_rd);
    chk(nwr == exp_wr, tmo ? "R5 no attn write" : "R7 write count", nwr, exp_wr);
    chk(wr_addr[wr_base % 16] == 2'd0 && wr_data[wr_base % 16] == 8'h00,
        "R2 mask first", wr_data[wr_base % 16], 0);
    if (exp_rd > 0)
      chk(first_rd_wr == 1 && last_rd_wr == 1, "R3 reads between mask and attn",
          last_rd_wr, 1);
    if (!tmo) begin
      chk(wr_addr[(wr_base + 1) % 16] == 2'd2 && wr_data[(wr_base + 1) % 16] == exp_byte,
          "R6 attn byte", wr_data[(wr_base + 1) % 16], exp_byte);
      chk(wr_addr[(wr_base + 2) % 16] == 2'd0 && wr_data[(wr_base + 2) % 16] == 8'h01,
          "R7 unmask", wr_data[(wr_base + 2) % 16], 8'h01);
    end
  endtask

  // kind, dev, irq, busy reads
  localparam logic [26:0] VEC [8] = '{
    {4'h1, 3'd0, 4'h0, 16'd0},
    {4'h2, 3'd1, 4'h3, 16'd7},
    {4'h3, 3'd7, 4'hA, 16'd50},
    {4'h1, 3'd7, 4'h0, 16'd9999},
    {4'h2, 3'd1, 4'h0, 16'd12000},
    {4'h2, 3'd0, 4'hA, 16'd12000},
    {4'h1, 3'd5, 4'hB, 16'd3},
    {4'h3, 3'd1, 4'h8, 16'd1}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !tmo_o && !bus_en_o, "R1 reset state", bus_en_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !bus_en_o && wr_total == 0 && rd_total == 0,
        "R1 idle after reset", wr_total + rd_total, 0);

    for (int i = 0; i < 8; i++)
      run(VEC[i][26:23], VEC[i][22:20], VEC[i][19:16], int'(VEC[i][15:0]), 0);

    // R8: foreign start mid-sequence is ignored
    run(4'h1, 3'd1, 4'h0, 5, 3);
    repeat (6) @(negedge clk) begin
      chk(!done_o && !bus_en_o && !busy_o, "R8 no extra sequence", bus_en_o, 0);
    end

    // R9: timeout then boundary success again
    run(4'h2, 3'd0, 4'h0, 20000, 0);
    run(4'h1, 3'd1, 4'h0, 9999, 0);
    run(4'h2, 3'd1, 4'h0, 10000, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule